// File: doc/BRIEF.md
# Debug Trigger Pair Combiner

This block decides which of ten hardware debug triggers actually fire for the instruction under evaluation. Match detection happens elsewhere: the block receives one raw hit bit per trigger together with each trigger's enable, its timing choice and one chain-enable bit per pair, all held in control-register state. It applies the pairing rules and drives a registered fire vector and two trap requests. One request traps before the current instruction completes. The other traps on the following instruction.

The triggers form five fixed pairs. Trigger 2i and trigger 2i+1 make up pair i. The access class of each pair, by pair index, is: 0 fetch/fetch, 1 store/store, 2 load/load, 3 fetch/store (trigger 6 fetch, trigger 7 store), 4 fetch/load (trigger 8 fetch, trigger 9 load). A chained pair acts as one condition: both members must match, and both must ask for the same trap timing. Chaining two store triggers is not allowed, so pair 1 always behaves as two independent triggers. Three further flags report whether any fetch-class trigger fired, whether any memory-class (load or store) trigger fired, and whether any trigger fired at all.

Top module: `trig_chain_eval`

## Requirements
- R1: An unchained trigger fires exactly when its enable bit and its hit bit are both 1, whatever its partner's state.
- R2: With the chain bit of pair i set (i other than 1), triggers 2i and 2i+1 both fire when both are enabled, both hit and both timing bits are equal. Otherwise neither fires.
- R3: With the chain bit of a pair set, differing timing bits for its two members stop both from firing, even when both hit.
- R4: The chain bit of pair 1 (triggers 2 and 3, store/store) has no effect. Each of those triggers fires on its own enable and hit.
- R5: trap_now_o is 1 when any firing trigger has timing bit 0.
- R6: trap_next_o is 1 when any firing trigger has timing bit 1 and no firing trigger has timing bit 0. trap_now_o and trap_next_o are never both 1.
- R7: fetch_any_o is the OR of the fire bits of triggers 0, 1, 6 and 8. mem_any_o is the OR of the fire bits of triggers 2, 3, 4, 5, 7 and 9. any_fire_o is the OR of all ten fire bits.
- R8: All outputs are registered. They reflect the inputs present at the previous rising clock edge.
- R9: A reset, or flush_i high at a rising edge, sets every output to 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Pipeline flush; clears outputs at the next edge |
| hit_i | input | 10 | Raw per-trigger match results |
| en_i | input | 10 | Per-trigger enable |
| timing_i | input | 10 | Per-trigger timing: 0 trap before, 1 trap after |
| chain_i | input | 5 | Per-pair chain enable, bit i for triggers 2i and 2i+1 |
| fire_o | output | 10 | Per-trigger fire decision |
| trap_now_o | output | 1 | Trap before the current instruction |
| trap_next_o | output | 1 | Trap on the next instruction |
| fetch_any_o | output | 1 | Some fetch-class trigger fired |
| mem_any_o | output | 1 | Some load or store trigger fired |
| any_fire_o | output | 1 | Some trigger fired |

## Verification
Every output of this block is due exactly one rising edge after its inputs. The bench drives each stimulus on a falling edge and compares all outputs at the next falling edge, which falls half a period after the single register stage has loaded. The latency scenario also samples just after the inputs change, before any edge, and confirms that the outputs still show the previous result. The flush scenario holds inputs that would fire and checks for zeros one edge after flush_i is raised.

// File: rtl/trig_pkg.sv
package trig_pkg;

    localparam int NUM_PAIRS = 5;
    localparam int NUM_TRIG  = 2 * NUM_PAIRS;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } acc_class_e;

    // Fixed access class of every trigger slot
    function automatic acc_class_e class_of(input int idx);
        case (idx)
            0, 1, 6, 8: class_of = ACC_FETCH;
            2, 3, 7:    class_of = ACC_STORE;
            default:    class_of = ACC_LOAD;
        endcase
    endfunction

    // Store triggers may never be chained together
    function automatic bit chain_allowed(input int pair);
        chain_allowed = !(class_of(2 * pair) == ACC_STORE &&
                          class_of(2 * pair + 1) == ACC_STORE);
    endfunction

    function automatic logic [NUM_TRIG-1:0] class_mask(input acc_class_e c);
        logic [NUM_TRIG-1:0] m;
        for (int i = 0; i < NUM_TRIG; i++) m[i] = (class_of(i) == c);
        return m;
    endfunction

    typedef struct packed {
        logic [NUM_TRIG-1:0] fire;
        logic                trap_now;
        logic                trap_next;
        logic                fetch_any;
        logic                mem_any;
        logic                any_fire;
    } eval_out_t;

endpackage

// File: rtl/trig_pair_eval.sv
module trig_pair_eval
    import trig_pkg::*;
#(
    parameter int PAIR_IDX = 0
) (
    input  logic [1:0] hit,
    input  logic [1:0] en,
    input  logic [1:0] timing,
    input  logic       chain,
    output logic [1:0] fire
);
    localparam bit CAN_CHAIN = chain_allowed(PAIR_IDX);

    logic [1:0] own_match;
    logic       linked;
    logic       joint;

    always_comb begin
        own_match = hit & en;
        linked    = chain && CAN_CHAIN;
        joint     = own_match[0] && own_match[1] && (timing[0] == timing[1]);
        if (linked) fire = {joint, joint};
        else        fire = own_match;
    end
endmodule

// File: rtl/trig_summary.sv
module trig_summary
    import trig_pkg::*;
#(
    parameter int N = NUM_TRIG
) (
    input  logic [N-1:0] fire,
    input  logic [N-1:0] timing,
    output logic         trap_now,
    output logic         trap_next,
    output logic         fetch_any,
    output logic         mem_any
);
    localparam logic [N-1:0] FETCH_MASK = class_mask(ACC_FETCH);

    logic before_req;
    logic after_req;

    always_comb begin
        before_req = |(fire & ~timing);
        after_req  = |(fire & timing);
        trap_now   = before_req;
        trap_next  = after_req && !before_req;
        fetch_any  = |(fire & FETCH_MASK);
        mem_any    = |(fire & ~FETCH_MASK);
    end
endmodule

// File: rtl/trig_chain_eval.sv
module trig_chain_eval
    import trig_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush_i,
    input  logic [NUM_TRIG-1:0]  hit_i,
    input  logic [NUM_TRIG-1:0]  en_i,
    input  logic [NUM_TRIG-1:0]  timing_i,
    input  logic [NUM_PAIRS-1:0] chain_i,
    output logic [NUM_TRIG-1:0]  fire_o,
    output logic                 trap_now_o,
    output logic                 trap_next_o,
    output logic                 fetch_any_o,
    output logic                 mem_any_o,
    output logic                 any_fire_o
);
    logic [NUM_TRIG-1:0] fire_c;
    eval_out_t           next_c;
    eval_out_t           out_q;

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        trig_pair_eval #(.PAIR_IDX(p)) u_pair (
            .hit    (hit_i[2*p +: 2]),
            .en     (en_i[2*p +: 2]),
            .timing (timing_i[2*p +: 2]),
            .chain  (chain_i[p]),
            .fire   (fire_c[2*p +: 2])
        );
    end

    trig_summary #(.N(NUM_TRIG)) u_sum (
        .fire      (fire_c),
        .timing    (timing_i),
        .trap_now  (next_c.trap_now),
        .trap_next (next_c.trap_next),
        .fetch_any (next_c.fetch_any),
        .mem_any   (next_c.mem_any)
    );

    always_comb begin
        next_c.fire     = fire_c;
        next_c.any_fire = |fire_c;
    end

    always_ff @(posedge clk) begin
        if (rst || flush_i) out_q <= '0;
        else                out_q <= next_c;
    end

    assign fire_o      = out_q.fire;
    assign trap_now_o  = out_q.trap_now;
    assign trap_next_o = out_q.trap_next;
    assign fetch_any_o = out_q.fetch_any;
    assign mem_any_o   = out_q.mem_any;
    assign any_fire_o  = out_q.any_fire;
endmodule

// File: rtl/trig_chain_eval_chk.sv
module trig_chain_eval_chk
    import trig_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 flush_i,
    input logic [NUM_TRIG-1:0]  hit_i,
    input logic [NUM_TRIG-1:0]  en_i,
    input logic [NUM_TRIG-1:0]  timing_i,
    input logic [NUM_PAIRS-1:0] chain_i,
    input logic [NUM_TRIG-1:0]  fire_o,
    input logic                 trap_now_o,
    input logic                 trap_next_o,
    input logic                 fetch_any_o,
    input logic                 mem_any_o,
    input logic                 any_fire_o
);
    // R9
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (fire_o == '0 && !trap_now_o && !trap_next_o && !any_fire_o));

    // R6
    trap_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(trap_now_o && trap_next_o));

    // R5
    trap_needs_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (trap_now_o || trap_next_o) |-> (fire_o != '0));

    // R7
    any_matches_vec_chk: assert property (@(posedge clk) disable iff (rst)
        any_fire_o == (fire_o != '0));

    // R7
    class_flags_chk: assert property (@(posedge clk) disable iff (rst)
        any_fire_o == (fetch_any_o || mem_any_o));

    // R1
    disabled_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (en_i == '0) |=> (fire_o == '0));

    // R4
    store_pair_free_chk: assert property (@(posedge clk) disable iff (rst)
        (!flush_i && en_i[2] && hit_i[2]) |=> fire_o[2]);

    // R3
    timing_split_chk: assert property (@(posedge clk) disable iff (rst)
        (!flush_i && chain_i[0] && (timing_i[0] != timing_i[1])) |=> (fire_o[1:0] == 2'b00));

    // R2
    chained_both_chk: assert property (@(posedge clk) disable iff (rst)
        (!flush_i && chain_i[4] && !(hit_i[8] && hit_i[9])) |=> (fire_o[9:8] == 2'b00));
endmodule

bind trig_chain_eval trig_chain_eval_chk u_chk (.*);

// File: tb/trig_chain_eval_test.sv
module trig_chain_eval_test;
    import trig_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush_i = 1'b0;
    logic [9:0]  hit_i = '0, en_i = '0, timing_i = '0;
    logic [4:0]  chain_i = '0;
    logic [9:0]  fire_o;
    logic        trap_now_o, trap_next_o, fetch_any_o, mem_any_o, any_fire_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    trig_chain_eval uut (
        .clk(clk), .rst(rst), .flush_i(flush_i),
        .hit_i(hit_i), .en_i(en_i), .timing_i(timing_i), .chain_i(chain_i),
        .fire_o(fire_o), .trap_now_o(trap_now_o), .trap_next_o(trap_next_o),
        .fetch_any_o(fetch_any_o), .mem_any_o(mem_any_o), .any_fire_o(any_fire_o)
    );

    // Expected outputs from the requirements: {fire, now, next, fetch, mem, any}
    function automatic logic [14:0] model(input logic [9:0] h, input logic [9:0] e,
                                          input logic [9:0] t, input logic [4:0] c);
        logic [9:0] f;
        logic nw, nx;
        for (int k = 0; k < 10; k++) begin
            int mate = k ^ 1;
            bit linked = c[k/2] && (k/2 != 1);
            if (!linked) f[k] = e[k] && h[k];
            else f[k] = e[k] && h[k] && e[mate] && h[mate] && (t[k] == t[mate]);
        end
        nw = |(f & ~t);
        nx = (|(f & t)) && !nw;
        return {f, nw, nx, |(f & 10'b0101000011), |(f & 10'b1010111100), |f};
    endfunction

    function automatic logic [14:0] actual();
        return {fire_o, trap_now_o, trap_next_o, fetch_any_o, mem_any_o, any_fire_o};
    endfunction

    task automatic check(input string req, input logic [14:0] got, input logic [14:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic apply(input logic [9:0] h, input logic [9:0] e,
                         input logic [9:0] t, input logic [4:0] c);
        @(negedge clk);
        hit_i = h; en_i = e; timing_i = t; chain_i = c;
        @(negedge clk);
    endtask

    task automatic run(input string req, input logic [9:0] h, input logic [9:0] e,
                       input logic [9:0] t, input logic [4:0] c);
        apply(h, e, t, c);
        check(req, actual(), model(h, e, t, c));
    endtask

    task automatic t_reset();
        // R9: outputs zero after reset
        check("R9 reset", actual(), 15'd0);
    endtask

    task automatic t_unchained();
        run("R1 single fetch", 10'b0000000001, 10'h3FF, 10'h000, 5'b0);
        check("R5 trap_now", {14'd0, trap_now_o}, 15'd1);
        run("R1 hit not enabled", 10'b0000010000, 10'b1111101111, 10'h000, 5'b0);
        check("R1 silent", {5'd0, fire_o}, 15'd0);
        run("R7 memory class", 10'b1010000000, 10'h3FF, 10'h3FF, 5'b0);
        check("R7 mem flag", {13'd0, fetch_any_o, mem_any_o}, 15'd1);
        run("R1 partner ignored", 10'b0100000000, 10'h3FF, 10'h000, 5'b01111 & 5'b0);
    endtask

    task automatic t_chain();
        run("R2 both hit", 10'b0000000011, 10'h3FF, 10'h000, 5'b00001);
        check("R2 both fire", {5'd0, fire_o}, 15'b11);
        run("R2 one hit", 10'b0000000001, 10'h3FF, 10'h000, 5'b00001);
        check("R2 none fire", {5'd0, fire_o}, 15'd0);
        run("R2 one disabled", 10'b1100000000, 10'b0100000000, 10'h000, 5'b10000);
        run("R2 fetch/store", 10'b0011000000, 10'h3FF, 10'h3FF, 5'b01000);
    endtask

    task automatic t_timing_split();
        run("R3 mismatch", 10'b0000110000, 10'h3FF, 10'b0000010000, 5'b00100);
        check("R3 neither fires", {5'd0, fire_o}, 15'd0);
    endtask

    task automatic t_store_pair();
        run("R4 store chain ignored", 10'b0000000100, 10'h3FF, 10'h000, 5'b00010);
        check("R4 trigger 2 fires", {5'd0, fire_o}, 15'b100);
        run("R4 store mismatch", 10'b0000001100, 10'h3FF, 10'b0000000100, 5'b00010);
        check("R4 both fire", {5'd0, fire_o}, 15'b1100);
    endtask

    task automatic t_priority();
        run("R6 mixed timing", 10'b0000000101, 10'h3FF, 10'b0000000100, 5'b0);
        check("R6 now wins", {13'd0, trap_now_o, trap_next_o}, 15'b10);
        run("R6 after only", 10'b0000000100, 10'h3FF, 10'b0000000100, 5'b0);
        check("R6 next only", {13'd0, trap_now_o, trap_next_o}, 15'b01);
    endtask

    task automatic t_latency();
        logic [14:0] prev;
        apply(10'd0, 10'd0, 10'd0, 5'd0);
        prev = actual();
        @(negedge clk);
        hit_i = 10'b0000000010; en_i = 10'h3FF; timing_i = '0; chain_i = '0;
        #1;
        check("R8 before edge", actual(), prev);
        @(negedge clk);
        check("R8 after edge", actual(), model(10'b0000000010, 10'h3FF, 10'd0, 5'd0));
    endtask

    task automatic t_flush();
        apply(10'h3FF, 10'h3FF, 10'h000, 5'b0);
        @(negedge clk);
        flush_i = 1'b1;
        @(negedge clk);
        check("R9 flush", actual(), 15'd0);
        flush_i = 1'b0;
        @(negedge clk);
        check("R9 resume", actual(), model(10'h3FF, 10'h3FF, 10'h000, 5'b0));
    endtask

    task automatic t_sweep();
        for (int n = 0; n < 300; n++) begin
            run("R2 sweep", 10'($urandom), 10'($urandom) | 10'($urandom),
                10'($urandom), 5'($urandom));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_unchained();
        t_chain();
        t_timing_split();
        t_store_pair();
        t_priority();
        t_latency();
        t_flush();
        t_sweep();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule